// File: doc/BRIEF.md
# Dual-Clock 9-Bit FIFO with Programmable Threshold Flags

This block buffers 9-bit words between a write clock and a read clock. The two clocks may be one net or fully unrelated. A word is stored only when both write strobes are high, and it is removed only when both read strobes are high. Writes into a full buffer are dropped, and reads from an empty buffer are dropped.

Four active-low status flags report the fill level. Full and almost-full belong to the write clock. Empty and almost-empty belong to the read clock. Each side learns the other side's pointer through a Gray-coded two-flop synchroniser. A flag therefore changes at once on its own side's operations. A change caused by the far side is delayed by a few edges of the flag's own clock.

The two almost-flag thresholds are 18-bit values, each made of a low and a high 9-bit byte. They are set through the data input while the offset-load pin is high. They can be read back through the data output in the same order.

An active-low output enable gates the data output. Gating changes nothing stored.

Top module: `pflag_fifo`

## Requirements
- R1: Words leave the buffer in the order they were accepted, with all 9 bits unchanged. `dout` shows the word on the read-clock edge after the one that removed it.
- R2: A word is stored only on a write-clock edge where `wr_en_a` and `wr_en_b` are both 1. A word is removed only on a read-clock edge where `rd_en_a` and `rd_en_b` are both 1. One strobe alone has no effect.
- R3: The capacity is DEPTH words (16 by default). While `full_n` is 0, a write strobe stores nothing and moves no pointer.
- R4: While `empty_n` is 0, a read strobe removes nothing and moves no pointer. The next word written is the next word read.
- R5: `afull_n` is 0 exactly when level + F + 1 >= DEPTH, where F is the almost-full threshold. After the far side stops moving, the level includes every completed operation.
- R6: `aempty_n` is 0 exactly when level <= E, where E is the almost-empty threshold. The same settling rule as R5 applies.
- R7: Strobed writes with `ofs_ld` = 1 do not enter the buffer. They store `din` into four byte slots, visited in this fixed cyclic order:
  - E low
  - E high
  - F low
  - F high
  
  Each threshold equals high × 512 + low.
- R8: Strobed reads with `ofs_ld` = 1 remove nothing. They put the four slots on `dout` in the same cyclic order, one slot per read edge. The read side keeps its own order counter.
- R9: Reset (`rst` = 1, synchronous, sampled by both clocks) empties the buffer and forces these flags:
  - `empty_n` = 0
  - `aempty_n` = 0
  - `full_n` = 1
  - `afull_n` = 1
  
  It also sets both thresholds to DEF_OFS (2) and returns both order counters to E low.
- R10: While `out_en_n` = 1, `dout_en` is 0 and `dout` is all zeros. Restoring `out_en_n` = 0 shows the held value again.
- R11: `full_n` falls right after the write edge that stores the DEPTH-th word. `empty_n` falls right after the read edge that removes the last word. `full_n` is never 1 while the write side sees DEPTH words. `empty_n` is never 1 while the read side sees zero words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset, sampled by both clocks |
| wr_en_a | input | 1 | First write strobe |
| wr_en_b | input | 1 | Second write strobe |
| din | input | 9 | Write data or threshold byte |
| rd_en_a | input | 1 | First read strobe |
| rd_en_b | input | 1 | Second read strobe |
| ofs_ld | input | 1 | Route strobes to the threshold slots |
| out_en_n | input | 1 | Active-low output enable |
| dout | output | 9 | Read data or threshold byte, zero while disabled |
| dout_en | output | 1 | High while the data output is driven |
| empty_n | output | 1 | Active-low empty flag (read clock) |
| full_n | output | 1 | Active-low full flag (write clock) |
| aempty_n | output | 1 | Active-low almost-empty flag (read clock) |
| afull_n | output | 1 | Active-low almost-full flag (write clock) |

## Verification
The most delicate overlap is a store and a removal in the same interval on unrelated clocks. Then each side's level is computed from a pointer that may be a few edges stale.

The bench runs the write clock at 20 ns and the read clock at 28 ns, so their edges drift through every relative phase. It holds the buffer about half full and fires both strobes together many times. Every removed word must match the bench's arithmetic model, and the flags must settle to the model's level. A second overlap is a write strobe against a full buffer. That word must never reappear when the buffer is drained.

// File: rtl/pflag_fifo_pkg.sv
package pflag_fifo_pkg;
  localparam int DATA_W = 9;
  localparam int OFS_W  = 2 * DATA_W;

  typedef enum logic [1:0] {
    SLOT_AE_LO = 2'd0,
    SLOT_AE_HI = 2'd1,
    SLOT_AF_LO = 2'd2,
    SLOT_AF_HI = 2'd3
  } ofs_slot_e;
endpackage

// File: rtl/pflag_fifo_sync.sv
module pflag_fifo_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/pflag_fifo_ram.sv
module pflag_fifo_ram #(
  parameter int AW = 4,
  parameter int DW = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [2**AW];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (rrst)    rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pflag_fifo_wr.sv
module pflag_fifo_wr
  import pflag_fifo_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int DEF_OFS = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1,
  localparam int XW = OFS_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_a,
  input  logic              en_b,
  input  logic              ld,
  input  logic [DATA_W-1:0] din,
  input  logic [PW-1:0]     rgray_s,
  output logic [PW-1:0]     wgray,
  output logic [AW-1:0]     waddr,
  output logic              push,
  output logic              full_n,
  output logic              afull_n,
  output logic [OFS_W-1:0]  ae_ofs,
  output logic [OFS_W-1:0]  af_ofs
);
  logic [PW-1:0] wptr, wptr_nxt, rbin, lvl_nxt, lvl_now;
  logic [XW-1:0] lvl_x;
  logic          cfg_wr;
  ofs_slot_e     slot;

  always_comb begin
    for (int i = 0; i < PW; i++) rbin[i] = ^(rgray_s >> i);
  end

  assign push     = en_a & en_b & ~ld & full_n;
  assign cfg_wr   = en_a & en_b & ld;
  assign wptr_nxt = wptr + PW'(push);
  assign lvl_nxt  = wptr_nxt - rbin;
  assign lvl_now  = wptr - rbin;
  assign lvl_x    = XW'(lvl_nxt);
  assign waddr    = wptr[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr    <= '0;
      wgray   <= '0;
      full_n  <= 1'b1;
      afull_n <= 1'b1;
      slot    <= SLOT_AE_LO;
      ae_ofs  <= OFS_W'(DEF_OFS);
      af_ofs  <= OFS_W'(DEF_OFS);
    end else begin
      wptr    <= wptr_nxt;
      wgray   <= wptr_nxt ^ (wptr_nxt >> 1);
      full_n  <= (lvl_nxt != PW'(DEPTH));
      afull_n <= (lvl_x + XW'(af_ofs) + XW'(1)) < XW'(DEPTH);
      if (cfg_wr) begin
        unique case (slot)
          SLOT_AE_LO: ae_ofs[DATA_W-1:0]     <= din;
          SLOT_AE_HI: ae_ofs[OFS_W-1:DATA_W] <= din;
          SLOT_AF_LO: af_ofs[DATA_W-1:0]     <= din;
          SLOT_AF_HI: af_ofs[OFS_W-1:DATA_W] <= din;
        endcase
        slot <= ofs_slot_e'(slot + 2'd1);
      end
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    !full_n |=> wptr == $past(wptr));

  // R3
  wr_level_chk: assert property (@(posedge clk) disable iff (rst)
    lvl_now <= PW'(DEPTH));

  // R11
  full_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (lvl_now == PW'(DEPTH)) |-> !full_n);
endmodule

// File: rtl/pflag_fifo_rd.sv
module pflag_fifo_rd
  import pflag_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1,
  localparam int XW = OFS_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_a,
  input  logic              en_b,
  input  logic              ld,
  input  logic [PW-1:0]     wgray_s,
  input  logic [OFS_W-1:0]  ae_ofs,
  input  logic [OFS_W-1:0]  af_ofs,
  output logic [PW-1:0]     rgray,
  output logic [AW-1:0]     raddr,
  output logic              pop,
  output logic              empty_n,
  output logic              aempty_n,
  output logic              show_cfg,
  output logic [DATA_W-1:0] cfg_q
);
  logic [PW-1:0] rptr, rptr_nxt, wbin, lvl_nxt, lvl_now;
  logic          cfg_rd;
  ofs_slot_e     slot;

  always_comb begin
    for (int i = 0; i < PW; i++) wbin[i] = ^(wgray_s >> i);
  end

  assign pop      = en_a & en_b & ~ld & empty_n;
  assign cfg_rd   = en_a & en_b & ld;
  assign rptr_nxt = rptr + PW'(pop);
  assign lvl_nxt  = wbin - rptr_nxt;
  assign lvl_now  = wbin - rptr;
  assign raddr    = rptr[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr     <= '0;
      rgray    <= '0;
      empty_n  <= 1'b0;
      aempty_n <= 1'b0;
      slot     <= SLOT_AE_LO;
      cfg_q    <= '0;
      show_cfg <= 1'b0;
    end else begin
      rptr     <= rptr_nxt;
      rgray    <= rptr_nxt ^ (rptr_nxt >> 1);
      empty_n  <= (lvl_nxt != '0);
      aempty_n <= XW'(lvl_nxt) > XW'(ae_ofs);
      if (cfg_rd) begin
        unique case (slot)
          SLOT_AE_LO: cfg_q <= ae_ofs[DATA_W-1:0];
          SLOT_AE_HI: cfg_q <= ae_ofs[OFS_W-1:DATA_W];
          SLOT_AF_LO: cfg_q <= af_ofs[DATA_W-1:0];
          SLOT_AF_HI: cfg_q <= af_ofs[OFS_W-1:DATA_W];
        endcase
        slot     <= ofs_slot_e'(slot + 2'd1);
        show_cfg <= 1'b1;
      end else if (pop) begin
        show_cfg <= 1'b0;
      end
    end
  end

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    !empty_n |=> rptr == $past(rptr));

  // R4
  rd_level_chk: assert property (@(posedge clk) disable iff (rst)
    lvl_now <= PW'(DEPTH));

  // R11
  empty_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (lvl_now == '0) |-> !empty_n);
endmodule

// File: rtl/pflag_fifo.sv
module pflag_fifo
  import pflag_fifo_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int DEF_OFS = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst,
  input  logic              wr_en_a,
  input  logic              wr_en_b,
  input  logic [DATA_W-1:0] din,
  input  logic              rd_en_a,
  input  logic              rd_en_b,
  input  logic              ofs_ld,
  input  logic              out_en_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              empty_n,
  output logic              full_n,
  output logic              aempty_n,
  output logic              afull_n
);
  logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0]     waddr, raddr;
  logic              push, pop, show_cfg;
  logic [OFS_W-1:0]  ae_ofs, af_ofs;
  logic [DATA_W-1:0] ram_q, cfg_q;

  pflag_fifo_wr #(.DEPTH(DEPTH), .DEF_OFS(DEF_OFS)) wr_i (
    .clk(wr_clk), .rst(rst), .en_a(wr_en_a), .en_b(wr_en_b), .ld(ofs_ld),
    .din(din), .rgray_s(rgray_s), .wgray(wgray), .waddr(waddr), .push(push),
    .full_n(full_n), .afull_n(afull_n), .ae_ofs(ae_ofs), .af_ofs(af_ofs)
  );

  pflag_fifo_rd #(.DEPTH(DEPTH)) rd_i (
    .clk(rd_clk), .rst(rst), .en_a(rd_en_a), .en_b(rd_en_b), .ld(ofs_ld),
    .wgray_s(wgray_s), .ae_ofs(ae_ofs), .af_ofs(af_ofs), .rgray(rgray),
    .raddr(raddr), .pop(pop), .empty_n(empty_n), .aempty_n(aempty_n),
    .show_cfg(show_cfg), .cfg_q(cfg_q)
  );

  pflag_fifo_sync #(.W(PW)) w2r_i (
    .clk(rd_clk), .rst(rst), .d(wgray), .q(wgray_s)
  );

  pflag_fifo_sync #(.W(PW)) r2w_i (
    .clk(wr_clk), .rst(rst), .d(rgray), .q(rgray_s)
  );

  pflag_fifo_ram #(.AW(AW), .DW(DATA_W)) ram_i (
    .wclk(wr_clk), .we(push), .waddr(waddr), .wdata(din),
    .rclk(rd_clk), .rrst(rst), .re(pop), .raddr(raddr), .rdata(ram_q)
  );

  assign dout_en = ~out_en_n;
  assign dout    = out_en_n ? '0 : (show_cfg ? cfg_q : ram_q);
endmodule

// File: tb/pflag_fifo_tb_top.sv
module pflag_fifo_tb_top;
  localparam int DEPTH = 16;

  logic       wr_clk = 1'b0, rd_clk = 1'b0, rst = 1'b1;
  logic       wr_en_a = 0, wr_en_b = 0, rd_en_a = 0, rd_en_b = 0;
  logic       ofs_ld = 0, out_en_n = 0;
  logic [8:0] din = '0;
  logic [8:0] dout;
  logic       dout_en, empty_n, full_n, aempty_n, afull_n;

  int total = 0, bad = 0, level = 0;
  int ae = 2, af = 2;
  bit done = 0;
  int model[$];

  always #10 wr_clk = ~wr_clk;
  always #14 rd_clk = ~rd_clk;

  pflag_fifo #(.DEPTH(DEPTH), .DEF_OFS(2)) dut_i (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .wr_en_a(wr_en_a),
    .wr_en_b(wr_en_b), .din(din), .rd_en_a(rd_en_a), .rd_en_b(rd_en_b),
    .ofs_ld(ofs_ld), .out_en_n(out_en_n), .dout(dout), .dout_en(dout_en),
    .empty_n(empty_n), .full_n(full_n), .aempty_n(aempty_n), .afull_n(afull_n)
  );

  task automatic chk(input int act, input int exp, input string req);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    #400;
  endtask

  task automatic chk_flags(input string ctx);
    chk(full_n,   (level != DEPTH) ? 1 : 0, {"R11 full_n ", ctx});
    chk(empty_n,  (level != 0) ? 1 : 0,     {"R4 empty_n ", ctx});
    chk(aempty_n, (level <= ae) ? 0 : 1,    {"R6 aempty_n ", ctx});
    chk(afull_n,  (level + af + 1 >= DEPTH) ? 0 : 1, {"R5 afull_n ", ctx});
  endtask

  task automatic wr_op(input logic a, input logic b, input logic ld, input logic [8:0] d);
    @(negedge wr_clk);
    wr_en_a = a; wr_en_b = b; ofs_ld = ld; din = d;
    @(negedge wr_clk);
    wr_en_a = 0; wr_en_b = 0; ofs_ld = 0;
  endtask

  task automatic rd_op(input logic a, input logic b, input logic ld, output logic [8:0] q);
    @(negedge rd_clk);
    rd_en_a = a; rd_en_b = b; ofs_ld = ld;
    @(negedge rd_clk);
    rd_en_a = 0; rd_en_b = 0; ofs_ld = 0;
    q = dout;
  endtask

  task automatic push(input logic [8:0] d);
    wr_op(1, 1, 0, d);
    if (level < DEPTH) begin
      model.push_back(int'(d));
      level++;
    end
  endtask

  task automatic pop_chk(input string req);
    logic [8:0] q;
    int exp;
    rd_op(1, 1, 0, q);
    if (level > 0) begin
      exp = model.pop_front();
      level--;
      chk(int'(q), exp, req);
    end
  endtask

  task automatic readback(input int e0, input int e1, input int e2, input int e3);
    logic [8:0] q;
    rd_op(1, 1, 1, q); chk(int'(q), e0, "R8 readback slot0");
    rd_op(1, 1, 1, q); chk(int'(q), e1, "R8 readback slot1");
    rd_op(1, 1, 1, q); chk(int'(q), e2, "R8 readback slot2");
    rd_op(1, 1, 1, q); chk(int'(q), e3, "R8 readback slot3");
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (4) @(negedge wr_clk);
    repeat (4) @(negedge rd_clk);
    rst = 0;
    model.delete();
    level = 0; ae = 2; af = 2;
    settle();
  endtask

  task automatic sweep_fill(input string tag);
    for (int i = 1; i <= DEPTH; i++) begin
      push(9'((i * 37 + 5) ^ 9'h155));
      if (i == DEPTH) chk(full_n, 0, "R11 full on filling edge");
      settle();
      chk_flags(tag);
    end
  endtask

  task automatic drain(input bit flags);
    for (int i = DEPTH; i >= 1; i--) begin
      pop_chk("R1 order");
      if (level == 0) chk(empty_n, 0, "R11 empty on draining edge");
      if (flags) begin
        settle();
        chk_flags("drain");
      end
    end
    settle();
  endtask

  initial begin
    logic [8:0] q, held;
    do_reset();
    // R9 reset state and default thresholds
    chk_flags("R9 after reset");
    readback(2, 0, 2, 0);

    // R5 R6 R11 fill sweep with default thresholds
    sweep_fill("default sweep");
    // R3 write into full buffer is dropped
    push(9'h1AA);
    settle();
    chk(full_n, 0, "R3 still full");
    drain(1);

    // R4 read from empty is ignored
    rd_op(1, 1, 0, q);
    settle();
    chk(empty_n, 0, "R4 empty after idle read");
    push(9'h0F3);
    settle();
    pop_chk("R4 next word after empty read");
    settle();

    // R2 single strobes have no effect
    wr_op(1, 0, 0, 9'h011); settle(); chk(empty_n, 0, "R2 wr_en_a alone");
    wr_op(0, 1, 0, 9'h022); settle(); chk(empty_n, 0, "R2 wr_en_b alone");
    push(9'h133); settle();
    rd_op(1, 0, 0, q); settle(); chk(empty_n, 1, "R2 rd_en_a alone");
    rd_op(0, 1, 0, q); settle(); chk(empty_n, 1, "R2 rd_en_b alone");
    pop_chk("R2 word survives lone strobes");
    settle();

    // R7 threshold load, then flag sweep with E=5 F=4
    wr_op(1, 1, 1, 9'd5); wr_op(1, 1, 1, 9'd0);
    wr_op(1, 1, 1, 9'd4); wr_op(1, 1, 1, 9'd0);
    ae = 5; af = 4;
    settle();
    chk(empty_n, 0, "R7 load writes do not enter buffer");
    readback(5, 0, 4, 0);
    sweep_fill("R7 loaded sweep");
    drain(0);

    // R7 wrap: fifth load goes back to E low; E = 1*512+3
    wr_op(1, 1, 1, 9'd1); wr_op(1, 1, 1, 9'd1);
    wr_op(1, 1, 1, 9'd7); wr_op(1, 1, 1, 9'd0);
    wr_op(1, 1, 1, 9'd3);
    ae = 515; af = 7;
    settle();
    readback(3, 1, 7, 0);
    sweep_fill("R7 wrap sweep");

    // R10 output enable gating
    pop_chk("R10 word before gating");
    held = dout;
    out_en_n = 1;
    #5;
    chk(dout_en, 0, "R10 dout_en off");
    chk(int'(dout), 0, "R10 dout zero");
    out_en_n = 0;
    #5;
    chk(dout_en, 1, "R10 dout_en on");
    chk(int'(dout), int'(held), "R10 value kept");
    drain(0);

    // R1 concurrent push and pop on unrelated clocks
    ae = 515; af = 7;
    for (int i = 0; i < 8; i++) push(9'(i * 19 + 1));
    settle();
    for (int i = 0; i < 40; i++) begin
      fork
        push(9'((i * 53 + 11) & 9'h1FF));
        pop_chk("R1 concurrent order");
      join
    end
    settle();
    chk_flags("R1 after concurrent");

    // R9 reset in mid sequence restores defaults and order counters
    wr_op(1, 1, 1, 9'd9); wr_op(1, 1, 1, 9'd9);
    do_reset();
    chk_flags("R9 second reset");
    readback(2, 0, 2, 0);
    wr_op(1, 1, 1, 9'd6); wr_op(1, 1, 1, 9'd0);
    wr_op(1, 1, 1, 9'd9); wr_op(1, 1, 1, 9'd0);
    settle();
    readback(6, 0, 9, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3000000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule